// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block decides, each cycle, whether a hart should take an interrupt and which one. It keeps a 32-bit pending-interrupt register that surrounding logic changes through a masked write port. While a write is presented, the port also shows the register contents from before the write. A second register records which pending bits are owned by hardware sources. A claim for a set of bits is refused when any of them is already owned.

The enable register, the delegation register, the current privilege level and the machine and supervisor global enable bits are inputs. The block combines them with the pending register to form a qualified set. It reports the lowest-numbered qualified bit as the cause through a one-cycle output register, together with a valid flag. A hard-interrupt request line follows whether the pending register holds any set bit. Trap entry, instruction decode and external interrupt controllers sit around this block.

Top module: `irq_prio_sel`

## Requirements
- R1: While rst_n is low, the pending and claim registers hold zero, and irq_valid, irq_cause and hard_req are all zero.
- R2: On a clock edge with upd_valid high, the pending register becomes (old AND NOT upd_mask) OR (upd_value AND upd_mask). It is unchanged on edges with upd_valid low.
- R3: upd_old always shows the current pending register, which is the value from before a write presented in the same cycle.
- R4: hard_req is high exactly when the pending register is non-zero. It therefore changes in the cycle after the write that caused the change.
- R5: Candidates are pending AND enable. A candidate whose delegation bit is 0 qualifies only when machine interrupts are globally enabled. That holds when priv is not 3 (machine), or when priv is 3 and m_ie is 1. The priv encoding is 0 user, 1 supervisor, 3 machine.
- R6: A candidate whose delegation bit is 1 qualifies only when supervisor interrupts are globally enabled. That holds when priv is 0, or when priv is 1 and s_ie is 1. Priv values 2 and 3 never enable delegated candidates.
- R7: One cycle after the inputs, irq_valid is 1 and irq_cause holds the index of the lowest set bit of the qualified set. When the qualified set is empty, irq_valid is 0 and irq_cause is 0.
- R8: claim_err is high when claim_valid is high and claim_bits overlaps claim_owned. In that case claim_owned is left unchanged. A claim without overlap ORs claim_bits into claim_owned at the clock edge, and an all-zero claim changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Apply a masked write to the pending register |
| upd_mask | input | 32 | Bits selected for writing |
| upd_value | input | 32 | New values for the selected bits |
| upd_old | output | 32 | Pending register contents before the write |
| hard_req | output | 1 | Pending register is non-zero |
| claim_valid | input | 1 | Claim request strobe |
| claim_bits | input | 32 | Bits requested for ownership |
| claim_err | output | 1 | Claim overlaps bits already owned |
| claim_owned | output | 32 | Bits owned by hardware sources |
| enable | input | 32 | Per-interrupt enable |
| deleg | input | 32 | Per-interrupt delegation to supervisor |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| irq_valid | output | 1 | An interrupt should be taken |
| irq_cause | output | 5 | Index of the interrupt to take |

## Verification
upd_old and claim_err are combinational and valid in the cycle their inputs are presented. The pending write, the claim update and hard_req show one edge after the request. The selector output reflects the enable, delegation and privilege inputs one edge later, and a pending write two edges later. The bench drives inputs shortly after a rising edge. Its reference model advances on that same edge from the inputs the design sampled, and every output is compared at the falling edge, where all of these latencies have settled.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_value,
  output logic [W-1:0] pend_q,
  output logic         any_pend
);
  logic [W-1:0] pend_d;

  always_comb begin
    pend_d = (pend_q & ~wr_mask) | (wr_value & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (wr_en) begin
      pend_q <= pend_d;
    end
  end

  assign any_pend = |pend_q;
endmodule

// File: rtl/irq_claim_reg.sv
module irq_claim_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] bits,
  output logic [W-1:0] owned_q,
  output logic         clash
);
  logic         grant;
  logic [W-1:0] owned_d;

  always_comb begin
    clash   = req & (|(owned_q & bits));
    grant   = req & ~clash;
    owned_d = owned_q | bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned_q <= '0;
    end else if (grant) begin
      owned_q <= owned_d;
    end
  end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_sel_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  pend,
  input  logic [W-1:0]  enable,
  input  logic [W-1:0]  deleg,
  input  priv_e         priv,
  input  logic          m_ie,
  input  logic          s_ie,
  output logic          hit,
  output logic [CW-1:0] cause
);
  logic         m_ok;
  logic         s_ok;
  logic [W-1:0] qual;

  always_comb begin
    m_ok = (priv != PRIV_M) | m_ie;
    s_ok = (priv == PRIV_U) | ((priv == PRIV_S) & s_ie);
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign qual[g] = pend[g] & enable[g] & (deleg[g] ? s_ok : m_ok);
  end

  always_comb begin
    cause = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (qual[i]) cause = CW'(i);
    end
    hit = |qual;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic [W-1:0]  upd_mask,
  input  logic [W-1:0]  upd_value,
  output logic [W-1:0]  upd_old,
  output logic          hard_req,
  input  logic          claim_valid,
  input  logic [W-1:0]  claim_bits,
  output logic          claim_err,
  output logic [W-1:0]  claim_owned,
  input  logic [W-1:0]  enable,
  input  logic [W-1:0]  deleg,
  input  logic [1:0]    priv,
  input  logic          m_ie,
  input  logic          s_ie,
  output logic          irq_valid,
  output logic [CW-1:0] irq_cause
);
  logic [W-1:0]  pend;
  logic          sel_hit;
  logic [CW-1:0] sel_cause;
  logic          valid_d;
  logic [CW-1:0] cause_d;

  irq_pend_reg #(.W(W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (upd_valid),
    .wr_mask  (upd_mask),
    .wr_value (upd_value),
    .pend_q   (pend),
    .any_pend (hard_req)
  );

  irq_claim_reg #(.W(W)) u_claim (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (claim_valid),
    .bits    (claim_bits),
    .owned_q (claim_owned),
    .clash   (claim_err)
  );

  irq_qualify #(.W(W), .CW(CW)) u_qual (
    .pend   (pend),
    .enable (enable),
    .deleg  (deleg),
    .priv   (priv_e'(priv)),
    .m_ie   (m_ie),
    .s_ie   (s_ie),
    .hit    (sel_hit),
    .cause  (sel_cause)
  );

  always_comb begin
    valid_d = sel_hit;
    cause_d = sel_hit ? sel_cause : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_cause <= '0;
    end else begin
      irq_valid <= valid_d;
      irq_cause <= cause_d;
    end
  end

  assign upd_old = pend;
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_valid,
  input logic [W-1:0]  upd_mask,
  input logic [W-1:0]  upd_value,
  input logic [W-1:0]  upd_old,
  input logic          hard_req,
  input logic          claim_valid,
  input logic [W-1:0]  claim_bits,
  input logic          claim_err,
  input logic [W-1:0]  claim_owned,
  input logic [W-1:0]  enable,
  input logic          irq_valid,
  input logic [CW-1:0] irq_cause
);
  assert_pend_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> upd_old == (($past(upd_old) & ~$past(upd_mask)) | ($past(upd_value) & $past(upd_mask))));

  assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(upd_old));

  assert_hard_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hard_req));

  assert_claim_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_valid && claim_err) |=> $stable(claim_owned));

  assert_claim_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_valid && !claim_err) |=> claim_owned == ($past(claim_owned) | $past(claim_bits)));

  assert_cause_candidate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((($past(upd_old & enable)) >> irq_cause) & W'(1)) != '0);

  assert_idle_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_cause == '0);
endmodule

bind irq_prio_sel irq_prio_sel_chk #(.W(W), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .upd_mask    (upd_mask),
  .upd_value   (upd_value),
  .upd_old     (upd_old),
  .hard_req    (hard_req),
  .claim_valid (claim_valid),
  .claim_bits  (claim_bits),
  .claim_err   (claim_err),
  .claim_owned (claim_owned),
  .enable      (enable),
  .irq_valid   (irq_valid),
  .irq_cause   (irq_cause)
);

// File: tb/test_irq_prio_sel.sv
module test_irq_prio_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_mask = '0, upd_value = '0, upd_old;
  logic        hard_req;
  logic        claim_valid = 1'b0;
  logic [31:0] claim_bits = '0;
  logic        claim_err;
  logic [31:0] claim_owned;
  logic [31:0] enable = '0, deleg = '0;
  logic [1:0]  priv = 2'd3;
  logic        m_ie = 1'b0, s_ie = 1'b0;
  logic        irq_valid;
  logic [4:0]  irq_cause;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string tag_irq = "R7";

  logic [31:0] m_pend, m_claim;
  logic        m_valid;
  logic [4:0]  m_cause;

  always #10 clk = ~clk;

  irq_prio_sel i_irq_prio_sel (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_mask(upd_mask),
    .upd_value(upd_value), .upd_old(upd_old), .hard_req(hard_req),
    .claim_valid(claim_valid), .claim_bits(claim_bits), .claim_err(claim_err),
    .claim_owned(claim_owned), .enable(enable), .deleg(deleg), .priv(priv),
    .m_ie(m_ie), .s_ie(s_ie), .irq_valid(irq_valid), .irq_cause(irq_cause)
  );

  // Reference model: behavioural, advanced on the rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_claim = '0; m_valid = 1'b0; m_cause = '0;
    end else begin
      bit mok, sok, found;
      mok = (priv != 2'd3) || m_ie;
      sok = (priv == 2'd0) || (priv == 2'd1 && s_ie);
      found = 1'b0; m_cause = '0;
      for (int i = 0; i < 32; i++) begin
        if (!found && m_pend[i] && enable[i] && (deleg[i] ? sok : mok)) begin
          found = 1'b1; m_cause = 5'(i);
        end
      end
      m_valid = found;
      if (upd_valid) m_pend = (m_pend & ~upd_mask) | (upd_value & upd_mask);
      if (claim_valid && ((m_claim & claim_bits) == 0)) m_claim = m_claim | claim_bits;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1", "upd_old", upd_old, 32'h0);
        chk("R1", "claim_owned", claim_owned, 32'h0);
        chk("R1", "irq_valid", 32'(irq_valid), 32'h0);
        chk("R1", "irq_cause", 32'(irq_cause), 32'h0);
        chk("R1", "hard_req", 32'(hard_req), 32'h0);
      end else begin
        chk("R2", "pending", upd_old, m_pend);
        if (upd_valid) chk("R3", "upd_old during write", upd_old, m_pend);
        chk("R4", "hard_req", 32'(hard_req), 32'(m_pend != 0));
        chk(tag_irq, "irq_valid", 32'(irq_valid), 32'(m_valid));
        chk(tag_irq, "irq_cause", 32'(irq_cause), 32'(m_cause));
        chk("R8", "claim_owned", claim_owned, m_claim);
        chk("R8", "claim_err", 32'(claim_err),
            32'(claim_valid && ((m_claim & claim_bits) != 0)));
      end
    end
  end

  task automatic drive(bit uv, logic [31:0] um, logic [31:0] uval, bit cv,
                       logic [31:0] cb, logic [31:0] en, logic [31:0] dg,
                       logic [1:0] pr, bit mi, bit si);
    @(posedge clk); #2;
    upd_valid = uv; upd_mask = um; upd_value = uval;
    claim_valid = cv; claim_bits = cb;
    enable = en; deleg = dg; priv = pr; m_ie = mi; s_ie = si;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++)
      drive(0, 0, 0, 0, 0, enable, deleg, priv, m_ie, s_ie);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R2 / R3: masked writes
    drive(1, 32'hFFFF_FFFF, 32'h0000_0088, 0, 0, 0, 0, 3, 0, 0);
    drive(1, 32'h0000_00F0, 32'h0000_0F00, 0, 0, 0, 0, 3, 0, 0);
    drive(1, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 0, 0, 3, 0, 0);
    drive(1, 32'h8000_0009, 32'hFFFF_FFFF, 0, 0, 0, 0, 3, 0, 0);
    idle(2);
    // R4: clear all, then set one
    drive(1, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, 0, 3, 0, 0);
    idle(2);
    drive(1, 32'h0000_0088, 32'h0000_0088, 0, 0, 0, 0, 3, 0, 0);
    idle(2);
    // R5: non-delegated, pending bits 3 and 7
    tag_irq = "R5";
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 3, 0, 0); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 3, 1, 0); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 1, 0, 0); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFF7, 0, 0, 0, 0); idle(2);
    // R6: delegated
    tag_irq = "R6";
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 1, 1); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 1, 1); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0); idle(2);
    drive(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0008, 3, 1, 1); idle(2);
    // R7: lowest bit wins, empty set, top bit
    tag_irq = "R7";
    drive(1, 32'hFFFF_FFFF, 32'h8000_0001, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0); idle(2);
    drive(0, 0, 0, 0, 0, 32'h8000_0000, 0, 0, 0, 0); idle(2);
    drive(0, 0, 0, 0, 0, 32'h0000_0000, 0, 0, 0, 0); idle(2);
    // R8: claims
    drive(0, 0, 0, 1, 32'h0000_0011, enable, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 32'h0000_0110, enable, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 32'h0000_0000, enable, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 32'h0000_0600, enable, 0, 0, 0, 0);
    idle(2);
    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 3) == 0, $urandom, $urandom, ($urandom % 8) == 0,
            32'(1) << ($urandom % 32), $urandom, $urandom, 2'($urandom),
            1'($urandom), 1'($urandom));
    end
    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule